// File: doc/BRIEF.md
# Display Command Stream Register Decoder

This block sits behind a byte-wide streaming input that carries display control traffic as it arrives from a host link. It splits the stream into framed commands and acts on two of them. A register write updates one 8-bit video control register. A copy command asks the pixel engine to move a run of pixels. Every command opens with the sync byte 0xAF, followed by a code byte. Anything the parser cannot place is thrown away until the next sync byte.

Register updates use a lock protocol so that a whole video mode can change at one instant. While the lock is held, writes collect in a shadow bank. Releasing the lock copies the entire shadow bank into the active bank on a single clock edge. The active bank drives the outputs: the raw register vector, the colour depth flag, the two 24-bit framebuffer base addresses and the blank mode. A completed copy command raises a one-cycle strobe carrying its source address, destination address and pixel count.

The parser state machine has five states:
- `ST_HUNT` waits for the sync byte.
- `ST_CODE` holds the code byte.
- `ST_WR_IDX` takes the register index.
- `ST_WR_VAL` takes the register value.
- `ST_COPY_ARG` gathers the seven copy argument bytes.

Its transitions are:
- sync seen: `ST_HUNT` to `ST_CODE`
- noise: `ST_HUNT` to `ST_HUNT`
- resync: `ST_CODE` to `ST_CODE` on a further 0xAF
- write opcode: `ST_CODE` to `ST_WR_IDX`
- copy opcode: `ST_CODE` to `ST_COPY_ARG`
- unknown opcode: `ST_CODE` to `ST_HUNT`
- index taken: `ST_WR_IDX` to `ST_WR_VAL`
- value taken: `ST_WR_VAL` to `ST_HUNT`
- argument taken: stay in `ST_COPY_ARG`
- copy done: `ST_COPY_ARG` to `ST_HUNT` after the seventh argument

A state holds whenever `in_valid` is low.

Top module: `cmd_stream_regdec`

## Requirements
- R1: In the hunt state, any byte other than 0xAF is discarded with no effect on registers or the copy strobe, even if it looks like a command body.
- R2: The sequence 0xAF, 0x20, index, value writes value to register index. When unlocked, the new value appears on `reg_bank` (register i at bits [8i+7:8i]) from the clock edge that accepts the value byte. Indices of NUM_REGS (48) or above, other than 0xFF, change nothing.
- R3: A write of 0x00 to index 0xFF takes the lock. While locked, register writes leave every output of the active bank unchanged.
- R4: A write of 0xFF to index 0xFF releases the lock. Every staged value becomes visible together on the edge that accepts that value byte.
- R5: The sequence 0xAF, 0x6A, then source address (3 bytes, most significant first), pixel count (1 byte) and destination address (3 bytes, most significant first) produces `copy_valid` high for exactly one cycle. The pulse starts at the edge that accepts the ninth byte and carries those three fields.
- R6: After 0xAF, a code byte other than 0x20, 0x6A or 0xAF is dropped and the parser returns to hunting. The bytes after it are treated as noise.
- R7: A 0xAF in the code position restarts the command. A lone trailing 0xAF (padding) therefore causes no register change and no copy strobe, and the next command still parses.
- R8: `depth_24` is bit 0 of register 0x00. `base16` is registers 0x20, 0x21, 0x22, and `base8` is registers 0x26, 0x27, 0x28, each with the lowest index as the most significant byte.
- R9: `blank_mode` equals active register BLANK_IDX (0x1F).
- R10: Cycles with `in_valid` low between bytes do not disturb parsing. `in_ready` is always high.
- R11: After reset every register is 0x00, the bank is unlocked, `copy_valid` is low and the parser hunts.
- R12: A write to index 0xFF with a value other than 0x00 or 0xFF changes neither the lock state nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Byte accepted (always high) |
| reg_bank | output | NUM_REGS*8 | Active register bank, register i at [8i+7:8i] |
| depth_24 | output | 1 | Colour depth select, 1 = 24 bpp |
| base16 | output | 24 | Base address of the 16 bpp plane |
| base8 | output | 24 | Base address of the 8 bpp plane |
| blank_mode | output | 8 | Blank mode register |
| copy_valid | output | 1 | One-cycle copy request strobe |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |

## Verification
The bench first sends command bodies with no sync byte in front of them. A decoder that resynchronised on any byte would write registers from that noise. It then stages a full base address and the depth bit under lock and checks that nothing moves until the unlock. A bank that wrote through would expose a half-written base address. An unlock value that is not 0xFF must leave the lock held, so a decoder that tested only the index would commit early. Finally, a doubled sync byte, a trailing pad byte, an unknown code and back-to-back copies check the framing. A parser that miscounted argument bytes would pulse the copy strobe late, twice, or with fields shifted by a byte.

// File: rtl/cmdstream_pkg.sv
package cmdstream_pkg;
    localparam logic [7:0] SYNC_BYTE  = 8'hAF;
    localparam logic [7:0] OP_REG_WR  = 8'h20;
    localparam logic [7:0] OP_COPY    = 8'h6A;
    localparam logic [7:0] CTRL_IDX   = 8'hFF;
    localparam logic [7:0] LOCK_VAL   = 8'h00;
    localparam logic [7:0] UNLOCK_VAL = 8'hFF;
    localparam int         ADDR_BYTES = 3;
    localparam int         COPY_ARG_BYTES = 2 * ADDR_BYTES + 1;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CODE,
        ST_WR_IDX,
        ST_WR_VAL,
        ST_COPY_ARG
    } parse_state_e;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmdstream_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val,
    output logic       cp_byte_en,
    output logic       cp_last
);
    localparam int CNT_W = $clog2(COPY_ARG_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COPY_ARG_BYTES - 1);

    parse_state_e     state_q, state_d;
    logic [7:0]       idx_q;
    logic [CNT_W-1:0] argcnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (byte_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (byte_data == SYNC_BYTE) state_d = ST_CODE;
                end
                ST_CODE: begin
                    if (byte_data == SYNC_BYTE)      state_d = ST_CODE;
                    else if (byte_data == OP_REG_WR) state_d = ST_WR_IDX;
                    else if (byte_data == OP_COPY)   state_d = ST_COPY_ARG;
                    else                             state_d = ST_HUNT;
                end
                ST_WR_IDX:   state_d = ST_WR_VAL;
                ST_WR_VAL:   state_d = ST_HUNT;
                ST_COPY_ARG: begin
                    if (argcnt_q == CNT_LAST) state_d = ST_HUNT;
                end
                default:     state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // datapath registers: held index and argument counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            argcnt_q <= '0;
        end else if (byte_valid) begin
            if (state_q == ST_WR_IDX) idx_q <= byte_data;
            if (state_q == ST_COPY_ARG) begin
                argcnt_q <= (argcnt_q == CNT_LAST) ? '0 : argcnt_q + 1'b1;
            end else begin
                argcnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        wr_en      = byte_valid && (state_q == ST_WR_VAL);
        wr_idx     = idx_q;
        wr_val     = byte_data;
        cp_byte_en = byte_valid && (state_q == ST_COPY_ARG);
        cp_last    = cp_byte_en && (argcnt_q == CNT_LAST);
    end
endmodule

// File: rtl/vreg_bank.sv
module vreg_bank
    import cmdstream_pkg::*;
#(
    parameter int NUM_REGS = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_val,
    output logic [NUM_REGS*8-1:0] active_flat,
    output logic [NUM_REGS*8-1:0] shadow_flat,
    output logic                  locked,
    output logic                  commit
);
    logic [7:0] active_q [NUM_REGS];
    logic [7:0] shadow_q [NUM_REGS];
    logic       locked_q;
    logic       ctrl_wr, lock_set, data_wr;

    always_comb begin
        ctrl_wr  = wr_en && (wr_idx == CTRL_IDX);
        lock_set = ctrl_wr && (wr_val == LOCK_VAL);
        commit   = ctrl_wr && (wr_val == UNLOCK_VAL);
        data_wr  = wr_en && (32'(wr_idx) < NUM_REGS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (lock_set) locked_q <= 1'b1;
        else if (commit)   locked_q <= 1'b0;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = data_wr && (wr_idx == 8'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end else begin
                if (hit) shadow_q[i] <= wr_val;
                if (commit)                active_q[i] <= shadow_q[i];
                else if (hit && !locked_q) active_q[i] <= wr_val;
            end
        end

        assign active_flat[i*8 +: 8] = active_q[i];
        assign shadow_flat[i*8 +: 8] = shadow_q[i];
    end

    assign locked = locked_q;
endmodule

// File: rtl/copy_assembler.sv
module copy_assembler
    import cmdstream_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        last,
    input  logic [7:0]  byte_data,
    output logic        copy_valid,
    output logic [23:0] copy_src,
    output logic [7:0]  copy_count,
    output logic [23:0] copy_dst
);
    localparam int SR_W = (COPY_ARG_BYTES - 1) * 8;

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q       <= '0;
            copy_valid <= 1'b0;
            copy_src   <= '0;
            copy_count <= '0;
            copy_dst   <= '0;
        end else begin
            copy_valid <= last;
            if (byte_en) sr_q <= {sr_q[SR_W-9:0], byte_data};
            if (last) begin
                copy_src   <= sr_q[SR_W-1 -: 24];
                copy_count <= sr_q[SR_W-25 -: 8];
                copy_dst   <= {sr_q[15:0], byte_data};
            end
        end
    end
endmodule

// File: rtl/cmd_stream_regdec.sv
module cmd_stream_regdec #(
    parameter int NUM_REGS  = 48,
    parameter int BLANK_IDX = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic [NUM_REGS*8-1:0] reg_bank,
    output logic                  depth_24,
    output logic [23:0]           base16,
    output logic [23:0]           base8,
    output logic [7:0]            blank_mode,
    output logic                  copy_valid,
    output logic [23:0]           copy_src,
    output logic [7:0]            copy_count,
    output logic [23:0]           copy_dst
);
    localparam int DEPTH_REG = 8'h00;
    localparam int B16_REG   = 8'h20;
    localparam int B8_REG    = 8'h26;

    logic                  wr_en, cp_byte_en, cp_last;
    logic [7:0]            wr_idx, wr_val;
    logic [NUM_REGS*8-1:0] shadow_flat;
    logic                  lock_q, commit_evt;

    assign in_ready = 1'b1;

    cmd_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (in_valid),
        .byte_data  (in_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_val     (wr_val),
        .cp_byte_en (cp_byte_en),
        .cp_last    (cp_last)
    );

    vreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val),
        .active_flat (reg_bank),
        .shadow_flat (shadow_flat),
        .locked      (lock_q),
        .commit      (commit_evt)
    );

    copy_assembler u_copy (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (cp_byte_en),
        .last       (cp_last),
        .byte_data  (in_data),
        .copy_valid (copy_valid),
        .copy_src   (copy_src),
        .copy_count (copy_count),
        .copy_dst   (copy_dst)
    );

    assign depth_24   = reg_bank[DEPTH_REG*8];
    assign base16     = {reg_bank[B16_REG*8 +: 8], reg_bank[(B16_REG+1)*8 +: 8],
                         reg_bank[(B16_REG+2)*8 +: 8]};
    assign base8      = {reg_bank[B8_REG*8 +: 8], reg_bank[(B8_REG+1)*8 +: 8],
                         reg_bank[(B8_REG+2)*8 +: 8]};
    assign blank_mode = reg_bank[BLANK_IDX*8 +: 8];
endmodule

// File: rtl/cmd_stream_regdec_chk.sv
module cmd_stream_regdec_chk #(
    parameter int NUM_REGS = 48
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  copy_valid,
    input logic [NUM_REGS*8-1:0] bank,
    input logic [NUM_REGS*8-1:0] shadow,
    input logic                  locked,
    input logic                  commit
);
    AST_COPY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |=> !copy_valid); // R5

    AST_COPY_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> $past(in_valid)); // R5

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !commit) |=> $stable(bank)); // R3

    AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (bank == $past(shadow))); // R4

    AST_UNLOCKED_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (bank == shadow)); // R2
endmodule

bind cmd_stream_regdec cmd_stream_regdec_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .copy_valid (copy_valid),
    .bank       (reg_bank),
    .shadow     (shadow_flat),
    .locked     (lock_q),
    .commit     (commit_evt)
);

// File: tb/cmd_stream_regdec_tb.sv
module cmd_stream_regdec_tb;
    localparam int NUM_REGS = 48;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [7:0]            in_data = '0;
    logic                  in_ready;
    logic [NUM_REGS*8-1:0] reg_bank;
    logic                  depth_24;
    logic [23:0]           base16, base8;
    logic [7:0]            blank_mode;
    logic                  copy_valid;
    logic [23:0]           copy_src, copy_dst;
    logic [7:0]            copy_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [55:0] exp_q[$];
    logic [NUM_REGS*8-1:0] snap;

    always #2 clk = ~clk;

    cmd_stream_regdec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_bank(reg_bank), .depth_24(depth_24),
        .base16(base16), .base8(base8), .blank_mode(blank_mode),
        .copy_valid(copy_valid), .copy_src(copy_src), .copy_count(copy_count),
        .copy_dst(copy_dst)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bank(string req, logic [NUM_REGS*8-1:0] exp);
        checks++;
        if (reg_bank !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, reg_bank, exp);
        end
    endtask

    function automatic logic [7:0] rg(int i);
        return reg_bank[i*8 +: 8];
    endfunction

    task automatic send(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 8'h00;
        end
    endtask

    task automatic wr(logic [7:0] idx, logic [7:0] val);
        send(8'hAF); send(8'h20); send(idx); send(val);
    endtask

    task automatic copy_cmd(logic [23:0] s, logic [7:0] c, logic [23:0] d);
        exp_q.push_back({s, c, d});
        send(8'hAF); send(8'h6A);
        send(s[23:16]); send(s[15:8]); send(s[7:0]);
        send(c);
        send(d[23:16]); send(d[15:8]); send(d[7:0]);
    endtask

    // scoreboard monitor for copy strobes (R5)
    always @(negedge clk) begin
        if (rst_n && copy_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5: unexpected copy strobe %h %h %h expected none",
                         copy_src, copy_count, copy_dst);
            end else begin
                logic [55:0] e;
                e = exp_q.pop_front();
                if ({copy_src, copy_count, copy_dst} !== e) begin
                    errors++;
                    $display("FAIL R5: actual %h expected %h",
                             {copy_src, copy_count, copy_dst}, e);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check_bank("R11 bank", '0);
        check("R11 copy_valid", 32'(copy_valid), 0);
        check("R10 in_ready", 32'(in_ready), 1);

        // R1 command body without sync byte
        send(8'h11); send(8'h20); send(8'h05); send(8'h77);
        idle(1);
        check_bank("R1 noise", '0);

        // R2 plain write
        wr(8'h05, 8'h5A); idle(1);
        check("R2 reg5", 32'(rg(5)), 32'h5A);

        // R10 stalls between bytes
        send(8'hAF); idle(3); send(8'h20); idle(1); send(8'h06); idle(2);
        send(8'h3C); idle(1);
        check("R10 reg6", 32'(rg(6)), 32'h3C);

        // R2 out-of-range index
        snap = reg_bank;
        wr(8'h30, 8'h99); idle(1);
        check_bank("R2 out of range", snap);

        // R3 locked staging
        wr(8'hFF, 8'h00);
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        wr(8'h00, 8'h01);
        idle(1);
        check("R3 base16 held", 32'(base16), 0);
        check("R3 depth held", 32'(depth_24), 0);
        // R12 bad control value keeps lock
        wr(8'hFF, 8'h55); idle(1);
        check("R12 base16 still held", 32'(base16), 0);
        // R4 unlock commits together
        wr(8'hFF, 8'hFF); idle(1);
        check("R4 base16", 32'(base16), 32'h123456);
        check("R4 depth_24", 32'(depth_24), 1);

        // R8 8 bpp base, R9 blank mode
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF); idle(1);
        check("R8 base8", 32'(base8), 32'hABCDEF);
        wr(8'h1F, 8'h02); idle(1);
        check("R9 blank_mode", 32'(blank_mode), 2);

        // R5 copies, back to back
        copy_cmd(24'h010203, 8'h10, 24'h040506);
        copy_cmd(24'hF0E0D0, 8'hFF, 24'h0A0B0C);
        idle(2);
        check("R5 queue drained", 32'(exp_q.size()), 0);

        // R6 unknown code
        send(8'hAF); send(8'h33); send(8'h20); send(8'h07); send(8'h44);
        idle(1);
        check("R6 reg7", 32'(rg(7)), 0);

        // R7 doubled sync
        send(8'hAF); wr(8'h08, 8'h66); idle(1);
        check("R7 reg8", 32'(rg(8)), 32'h66);
        // R7 trailing pad
        snap = reg_bank;
        send(8'hAF); idle(4);
        check_bank("R7 pad", snap);
        wr(8'h09, 8'h11); idle(1);
        check("R7 after pad", 32'(rg(9)), 32'h11);
        check("R7 no copy", 32'(exp_q.size()), 0);

        idle(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule